// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block holds up to six bytes of instruction stream between a bus fetch engine and an instruction decoder. While there is room, it asks the bus side for the next word of code at its own fetch offset within the code segment. The fetch side returns two bytes per request, and the block stores them low byte first. The decoder takes one byte per cycle in program order. Fetching therefore runs ahead of execution and overlaps it. The physical address (segment base shifted and added to the offset) is formed outside the block from `req_off_o`.

When control flow changes, the decoder side raises a flush with the new offset. In one cycle the block empties the queue, loads the offset and flips a one-bit epoch. Every request carries the epoch as a tag. A response that arrives with the old tag is dropped, so bytes from the abandoned stream never enter the queue.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `count_o` is 0, `pop_valid_o` is 0, `req_off_o` is 0000h and `req_tag_o` is 0. `count_o` never exceeds 6.
- R2: Bytes leave in the order they were fetched. In a returned word, bits [7:0] are the earlier byte and bits [15:8] the later one.
- R3: `req_o` is high exactly when no request is outstanding, `flush_i` is low and at least 2 entries are free (`count_o` ≤ 4). A cycle with `req_o` and `gnt_i` both high advances `req_off_o` by 2 on the next cycle.
- R4: At most one request is outstanding at a time. A response is stored only if a request is outstanding and `rsp_tag_i` equals `req_tag_o`.
- R5: A cycle with `flush_i` high leaves `count_o` = 0, `req_off_o` = `flush_off_i` and `req_tag_o` inverted on the next cycle. A response carrying the previous tag is then discarded.
- R6: A pop while `count_o` is 0 is ignored: `stall_o` is high in that cycle and `count_o` stays 0.
- R7: A push and a pop in the same cycle change `count_o` by +1 (2 in, 1 out), and ordering is kept.
- R8: The fetch offset wraps from FFFEh to 0000h within the segment.
- R9: `pop_valid_o` is high exactly when `count_o` is nonzero, and `pop_data_o` then shows the oldest byte.
- R10: `req_tag_o` shows the current epoch, and a request takes that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the queue and redirect fetching |
| flush_off_i | input | 16 | New fetch offset loaded on flush |
| gnt_i | input | 1 | Bus side accepts the current request |
| rsp_valid_i | input | 1 | Returned code word is valid |
| rsp_data_i | input | 16 | Returned code word, earlier byte in [7:0] |
| rsp_tag_i | input | 1 | Epoch tag of the returned word |
| pop_i | input | 1 | Decoder takes one byte |
| req_o | output | 1 | Fetch request |
| req_off_o | output | 16 | Offset in the code segment to fetch from |
| req_tag_o | output | 1 | Current epoch, to be returned with the data |
| pop_data_o | output | 8 | Oldest byte in the queue |
| pop_valid_o | output | 1 | Queue not empty |
| stall_o | output | 1 | Pop attempted on an empty queue |
| count_o | output | 3 | Number of bytes held |

## Verification
The hardest case is a stale word arriving after a redirect. This needs a grant, then a flush before the response returns, and then a response with the old tag while the queue is empty and a new request may already be asked for. The stimulus table builds this up cycle by cycle. It also checks the opposite order, a stale word arriving while a fresh request is outstanding. Two other cases come from the same walk: an offset that has just been loaded near the top of the segment and wraps on the next grant, and the queue filled to six so that `req_o` must hold off even with `gnt_i` high.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  parameter int FB    = 2,
  parameter int OFF_W = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [OFF_W-1:0] flush_off_i,
  input  logic             gnt_i,
  input  logic             rsp_valid_i,
  input  logic [DW*FB-1:0] rsp_data_i,
  input  logic             rsp_tag_i,
  input  logic             pop_i,
  output logic             req_o,
  output logic [OFF_W-1:0] req_off_o,
  output logic             req_tag_o,
  output logic [DW-1:0]    pop_data_o,
  output logic             pop_valid_o,
  output logic             stall_o,
  output logic [CW-1:0]    count_o
);

  localparam logic [CW-1:0]    FILL_MAX = CW'(DEPTH - FB);
  localparam logic [CW-1:0]    FB_C     = CW'(FB);
  localparam logic [OFF_W-1:0] STEP     = OFF_W'(FB);

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    rd_q, wr_q, rd_nxt, wr_nxt;
  logic [PW-1:0]    wr_idx [FB];
  logic [CW-1:0]    cnt_q;
  logic [OFF_W-1:0] off_q;
  logic             epoch_q, pend_q;
  logic             do_push, do_pop;

  assign do_push = rsp_valid_i && pend_q && (rsp_tag_i == epoch_q) && !flush_i;
  assign do_pop  = pop_i && (cnt_q != '0) && !flush_i;

  assign req_o       = !pend_q && !flush_i && (cnt_q <= FILL_MAX);
  assign req_off_o   = off_q;
  assign req_tag_o   = epoch_q;
  assign pop_data_o  = mem[rd_q];
  assign pop_valid_o = (cnt_q != '0);
  assign stall_o     = pop_i && (cnt_q == '0);
  assign count_o     = cnt_q;

  for (genvar i = 0; i < FB; i++) begin : g_widx
    assign wr_idx[i] = (32'(wr_q) + i >= DEPTH) ? PW'(32'(wr_q) + i - DEPTH)
                                                : PW'(32'(wr_q) + i);
  end

  assign wr_nxt = (32'(wr_q) + FB >= DEPTH) ? PW'(32'(wr_q) + FB - DEPTH)
                                            : PW'(32'(wr_q) + FB);
  assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);

  always_ff @(posedge clk) begin
    if (do_push) begin
      for (int i = 0; i < FB; i++) mem[wr_idx[i]] <= rsp_data_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      epoch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (flush_i) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      off_q   <= flush_off_i;
      epoch_q <= !epoch_q;
      pend_q  <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_nxt;
      if (do_pop)  rd_q <= rd_nxt;
      cnt_q <= cnt_q + (do_push ? FB_C : '0) - (do_pop ? CW'(1) : '0);
      if (req_o && gnt_i) begin
        off_q  <= off_q + STEP;
        pend_q <= 1'b1;
      end else if (do_push) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

module prefetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int FB    = 2,
  parameter int OFF_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic [OFF_W-1:0] flush_off_i,
  input logic             gnt_i,
  input logic             req_o,
  input logic [OFF_W-1:0] req_off_o,
  input logic             req_tag_o,
  input logic             stall_o,
  input logic [CW-1:0]    count_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH)); // R1
  AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (count_o <= CW'(DEPTH - FB))); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> !req_o); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_o == '0) && (req_off_o == $past(flush_off_i))
                && (req_tag_o != $past(req_tag_o))); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !flush_i) |=> (count_o <= CW'(FB))); // R6
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> (req_off_o == $past(req_off_o) + OFF_W'(FB))); // R8
endmodule

bind prefetch_queue prefetch_queue_chk #(.DEPTH(DEPTH), .FB(FB), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_off_i(flush_off_i),
  .gnt_i(gnt_i), .req_o(req_o), .req_off_o(req_off_o), .req_tag_o(req_tag_o),
  .stall_o(stall_o), .count_o(count_o));

// File: tb/prefetch_queue_tb_top.sv
module prefetch_queue_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, gnt_i = 1'b0, rsp_valid_i = 1'b0, rsp_tag_i = 1'b0, pop_i = 1'b0;
  logic [15:0] flush_off_i = '0, rsp_data_i = '0;
  logic req_o, req_tag_o, pop_valid_o, stall_o;
  logic [15:0] req_off_o;
  logic [7:0] pop_data_o;
  logic [2:0] count_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  prefetch_queue dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_off_i(flush_off_i),
    .gnt_i(gnt_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .rsp_tag_i(rsp_tag_i), .pop_i(pop_i), .req_o(req_o), .req_off_o(req_off_o),
    .req_tag_o(req_tag_o), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .stall_o(stall_o), .count_o(count_o));

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // {flush, flush_off, gnt, rsp_valid, tag_current, rsp_data, pop,
  //  exp_req, exp_stall, check_data, exp_data, exp_count, exp_off}
  localparam logic [66:0] VEC [25] = '{
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd0,16'h0000},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd0,16'h0002},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'hB2A1,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd2,16'h0002},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd2,16'h0004},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'hD4C3,1'b1, 1'b0,1'b0,1'b1,8'hA1,3'd3,16'h0004},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b0,1'b1,8'hB2,3'd2,16'h0006},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'hF6E5,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd4,16'h0006},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd4,16'h0008},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'h1807,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd6,16'h0008},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd6,16'h0008},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b0,1'b0,1'b1,8'hC3,3'd5,16'h0008},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b0,1'b0,1'b1,8'hD4,3'd4,16'h0008},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b0,1'b1,8'hE5,3'd3,16'h0008},
    {1'b1,16'hFFFC,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b0,1'b0,1'b0,8'h00,3'd0,16'hFFFC},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b1,1'b0,8'h00,3'd0,16'hFFFE},
    {1'b0,16'h0000,1'b0,1'b1,1'b0,16'h5555,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd0,16'hFFFE},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'h2211,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd2,16'hFFFE},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd2,16'h0000},
    {1'b1,16'h1234,1'b0,1'b0,1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b0,8'h00,3'd0,16'h1234},
    {1'b0,16'h0000,1'b0,1'b1,1'b0,16'h9999,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd0,16'h1234},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b1,1'b0,8'h00,3'd0,16'h1234},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0, 1'b1,1'b0,1'b0,8'h00,3'd0,16'h1236},
    {1'b0,16'h0000,1'b0,1'b1,1'b1,16'hBBAA,1'b1, 1'b0,1'b1,1'b0,8'h00,3'd2,16'h1236},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b0,1'b1,8'hAA,3'd1,16'h1236},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b1,1'b0,1'b1,8'hBB,3'd0,16'h1236}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R10: reset state
    chk("count R1", 16'(count_o), 16'h0);
    chk("pop_valid R1", 16'(pop_valid_o), 16'h0);
    chk("offset R1", req_off_o, 16'h0);
    chk("req_tag R1 R10", 16'(req_tag_o), 16'h0);

    for (int i = 0; i < 25; i++) begin
      logic [66:0] v;
      v = VEC[i];
      flush_i = v[66]; flush_off_i = v[65:50]; gnt_i = v[49]; rsp_valid_i = v[48];
      rsp_tag_i = v[47] ? req_tag_o : !req_tag_o;
      rsp_data_i = v[46:31]; pop_i = v[30];
      #1;
      chk($sformatf("row%0d req_o R3 R4", i), 16'(req_o), 16'(v[29]));
      chk($sformatf("row%0d stall R6", i), 16'(stall_o), 16'(v[28]));
      if (v[27]) chk($sformatf("row%0d data R2 R7 R9", i), 16'(pop_data_o), 16'(v[26:19]));
      @(negedge clk);
      flush_i = 1'b0; gnt_i = 1'b0; rsp_valid_i = 1'b0; pop_i = 1'b0;
      chk($sformatf("row%0d count R1 R4 R5 R7", i), 16'(count_o), 16'(v[18:16]));
      chk($sformatf("row%0d offset R3 R5 R8", i), req_off_o, v[15:0]);
      chk($sformatf("row%0d pop_valid R9", i), 16'(pop_valid_o), 16'(v[18:16] != 3'd0));
    end

    // R10: epoch flipped twice by the two flushes, then once more
    chk("req_tag R10", 16'(req_tag_o), 16'h0);
    flush_i = 1'b1; flush_off_i = 16'hABCE;
    @(negedge clk);
    flush_i = 1'b0;
    chk("req_tag after flush R5 R10", 16'(req_tag_o), 16'h1);

    // R1: reset while holding data
    gnt_i = 1'b1;
    @(negedge clk);
    gnt_i = 1'b0; rsp_valid_i = 1'b1; rsp_tag_i = 1'b1; rsp_data_i = 16'h7766;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    chk("count before reset R4", 16'(count_o), 16'h2);
    chk("head before reset R2", 16'(pop_data_o), 16'h66);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("count after reset R1", 16'(count_o), 16'h0);
    chk("offset after reset R1", req_off_o, 16'h0);
    chk("req_tag after reset R1", 16'(req_tag_o), 16'h0);
    finish_run();
  end
endmodule